// File: doc/BRIEF.md
# Word-to-Byte Data FIFO Packer

This block sits between a 16-bit host data port and a byte-wide serial bus engine. It holds up to four bytes in one shared store. A host write queues a pair of bytes for transmission. The engine pulls those bytes out one at a time. Going the other way, the engine deposits received bytes one at a time and the host collects them two at a time.

A single byte-order input chooses which half of the host word travels first. The block keeps five status indications for the surrounding controller: receive data ready, transmit space ready, receive overrun, transmit underflow, and a pulse when a host read finds only one byte left. Bus timing and interrupt generation belong to neighbouring logic.

When the host and the engine act in the same cycle, the host access takes effect first. The engine then works on the state that the host access leaves behind.

Top module: `word_byte_packer`

## Requirements
- R1: An accepted host write shifts the store up by 16 bits and adds 2 to the transmit count. The new word fills bits 15:0. With `big_endian`=1 the word's high byte lands in bits 15:8. With `big_endian`=0 its low byte lands in bits 15:8.
- R2: A host write is ignored when more than 2 transmit bytes are queued. The store, the count and every flag are left unchanged.
- R3: `eng_tx_byte` shows byte index (transmit count − 1) of the store. An engine pop decrements the transmit count. Bytes therefore leave highest index first, so the older word goes out ahead of the newer one.
- R4: A pop with a transmit count of 0 gives `eng_tx_byte`=0 and sets `underflow`. An accepted host write clears `underflow`.
- R5: A received byte is written at byte index equal to the receive count, and the count then increments. When 4 bytes are already held, the byte is dropped and `overrun` is set. Any host read clears `overrun`.
- R6: `host_rdata` returns store bytes 1 and 0 as {b1,b0} when `big_endian`=0, and as {b0,b1} when it is 1. A read with more than 2 bytes held shifts the store down by 16 bits. A read with 2 or more bytes held lowers the receive count by 2.
- R7: A host read with exactly 1 byte held clears the receive count. It also raises `single_byte` for exactly one cycle, in the cycle after the read.
- R8: `tx_ready` is set by every engine pop. It is cleared by an accepted write that leaves more than 2 bytes queued.
- R9: `rx_ready` is set by every engine push. It is cleared by a host read that leaves the receive count at 0.
- R10: When host and engine access the same cycle, the host access is applied first. A pop sees the bytes of a write made in that cycle. A push lands after the shift and count drop of a read made in that cycle.
- R11: After reset the store, both counts and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Host-side byte order select |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host data read strobe |
| host_rdata | output | 16 | Host read word (combinational from store) |
| eng_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Next transmit byte, 0 when none queued |
| eng_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Receive data available |
| tx_ready | output | 1 | Transmit space freed by a pop |
| overrun | output | 1 | Receive byte dropped while full |
| underflow | output | 1 | Pop made with nothing queued |
| single_byte | output | 1 | One-cycle pulse: a read found one byte |

## Verification
The assertions treat every strobe as a single-cycle request that is sampled only after reset is released. Every strobe is assumed legal in any combination, including a host write together with a pop, and a host read together with a push. The stimulus drives all inputs on the falling edge and holds each strobe for exactly one cycle. It also deliberately pairs host and engine strobes in the same cycle, so that the ordering rule is exercised and not merely assumed.

// File: rtl/word_byte_packer.sv
module word_byte_packer #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                big_endian,
  input  logic                host_wr,
  input  logic [2*BYTE_W-1:0] host_wdata,
  input  logic                host_rd,
  output logic [2*BYTE_W-1:0] host_rdata,
  input  logic                eng_pop,
  output logic [BYTE_W-1:0]   eng_tx_byte,
  input  logic                eng_push,
  input  logic [BYTE_W-1:0]   eng_rx_byte,
  output logic                rx_ready,
  output logic                tx_ready,
  output logic                overrun,
  output logic                underflow,
  output logic                single_byte
);
  localparam int HW      = 2 * BYTE_W;
  localparam int STORE_W = BYTE_W * SLOTS;
  localparam int CW      = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] FULL = CW'(SLOTS);
  localparam logic [CW-1:0] ROOM = CW'(SLOTS - 2);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  logic [STORE_W-1:0] store, st_h, st_n;
  logic [CW-1:0]      txc, rxc, txc_h, rxc_h, txc_n, rxc_n;
  logic               wr_ok, lone, empty_rd, pop_dry, push_full;
  logic [HW-1:0]      wr_word, low_word;

  assign wr_ok    = host_wr && (txc <= ROOM);
  assign wr_word  = big_endian ? host_wdata
                               : {host_wdata[BYTE_W-1:0], host_wdata[HW-1:BYTE_W]};
  assign low_word = store[HW-1:0];
  assign host_rdata = big_endian ? {low_word[BYTE_W-1:0], low_word[HW-1:BYTE_W]}
                                 : low_word;

  always_comb begin
    st_h  = store;
    txc_h = txc;
    rxc_h = rxc;
    lone  = 1'b0;
    if (wr_ok) begin
      st_h  = {store[STORE_W-HW-1:0], wr_word};
      txc_h = txc + TWO;
    end
    if (host_rd) begin
      if (rxc == ONE) begin
        lone  = 1'b1;
        rxc_h = '0;
      end else if (rxc > ONE) begin
        if (rxc > TWO) st_h = st_h >> HW;
        rxc_h = rxc - TWO;
      end
    end
  end

  assign empty_rd  = host_rd && (rxc_h == '0);
  assign pop_dry   = eng_pop && (txc_h == '0);
  assign push_full = eng_push && (rxc_h == FULL);

  always_comb begin
    eng_tx_byte = '0;
    if (txc_h != '0) eng_tx_byte = st_h[BYTE_W*(int'(txc_h)-1) +: BYTE_W];
  end

  always_comb begin
    st_n  = st_h;
    txc_n = txc_h;
    rxc_n = rxc_h;
    if (eng_pop && !pop_dry) txc_n = txc_h - ONE;
    if (eng_push && !push_full) begin
      st_n[BYTE_W*int'(rxc_h) +: BYTE_W] = eng_rx_byte;
      rxc_n = rxc_h + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store       <= '0;
      txc         <= '0;
      rxc         <= '0;
      rx_ready    <= 1'b0;
      tx_ready    <= 1'b0;
      overrun     <= 1'b0;
      underflow   <= 1'b0;
      single_byte <= 1'b0;
    end else begin
      store       <= st_n;
      txc         <= txc_n;
      rxc         <= rxc_n;
      single_byte <= lone;
      if (wr_ok) underflow <= 1'b0;
      if (pop_dry) underflow <= 1'b1;
      if (host_rd) overrun <= 1'b0;
      if (push_full) overrun <= 1'b1;
      if (wr_ok && txc_h > ROOM) tx_ready <= 1'b0;
      if (eng_pop) tx_ready <= 1'b1;
      if (empty_rd) rx_ready <= 1'b0;
      if (eng_push) rx_ready <= 1'b1;
    end
  end
endmodule

module packer_checker (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic host_rd,
  input logic eng_pop,
  input logic eng_push,
  input logic rx_ready,
  input logic tx_ready,
  input logic overrun,
  input logic underflow,
  input logic single_byte
);
  assert_underflow_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $past(eng_pop));
  assert_write_clears_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !underflow);
  assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(eng_push));
  assert_read_clears_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !overrun);
  assert_single_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(single_byte) |-> $past(host_rd));
  assert_single_is_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    single_byte |=> !single_byte);
  assert_pop_sets_txready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_pop |=> tx_ready);
  assert_push_sets_rxready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_push |=> rx_ready);
endmodule

bind word_byte_packer packer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .eng_pop(eng_pop), .eng_push(eng_push), .rx_ready(rx_ready),
  .tx_ready(tx_ready), .overrun(overrun), .underflow(underflow),
  .single_byte(single_byte)
);

// File: tb/test_word_byte_packer.sv
module test_word_byte_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0, host_wr = 1'b0, host_rd = 1'b0, eng_pop = 1'b0, eng_push = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  eng_rx_byte = '0;
  logic [15:0] host_rdata;
  logic [7:0]  eng_tx_byte;
  logic rx_ready, tx_ready, overrun, underflow, single_byte;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  word_byte_packer i_word_byte_packer (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .eng_pop(eng_pop), .eng_tx_byte(eng_tx_byte),
    .eng_push(eng_push), .eng_rx_byte(eng_rx_byte), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .overrun(overrun), .underflow(underflow),
    .single_byte(single_byte)
  );

  // op: 0 write, 1 read (check host_rdata), 2 push, 3 pop (check eng_tx_byte)
  localparam int NV = 21;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h1234, 16'h0000},
    {2'd3, 1'b0, 16'h0000, 16'h0034},
    {2'd3, 1'b0, 16'h0000, 16'h0012},
    {2'd3, 1'b0, 16'h0000, 16'h0000},
    {2'd0, 1'b1, 16'hABCD, 16'h0000},
    {2'd0, 1'b1, 16'h5678, 16'h0000},
    {2'd0, 1'b1, 16'h9999, 16'h0000},
    {2'd3, 1'b1, 16'h0000, 16'h00AB},
    {2'd3, 1'b1, 16'h0000, 16'h00CD},
    {2'd3, 1'b1, 16'h0000, 16'h0056},
    {2'd3, 1'b1, 16'h0000, 16'h0078},
    {2'd2, 1'b0, 16'h0011, 16'h0000},
    {2'd2, 1'b0, 16'h0022, 16'h0000},
    {2'd2, 1'b0, 16'h0033, 16'h0000},
    {2'd2, 1'b0, 16'h0044, 16'h0000},
    {2'd2, 1'b0, 16'h0055, 16'h0000},
    {2'd1, 1'b0, 16'h0000, 16'h2211},
    {2'd1, 1'b0, 16'h0000, 16'h4433},
    {2'd2, 1'b1, 16'h00A1, 16'h0000},
    {2'd2, 1'b1, 16'h00B2, 16'h0000},
    {2'd1, 1'b1, 16'h0000, 16'hA1B2}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic push, input logic pop,
                       input logic [15:0] wd, input logic [7:0] rb);
    @(negedge clk);
    host_wr = wr; host_rd = rd; eng_push = push; eng_pop = pop;
    host_wdata = wd; eng_rx_byte = rb;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    host_wr = 0; host_rd = 0; eng_push = 0; eng_pop = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    idle();
    chk("R11 flags", {11'd0, rx_ready, tx_ready, overrun, underflow, single_byte}, 16'h0);
    chk("R11 tx byte", {8'h0, eng_tx_byte}, 16'h0);
    chk("R11 rdata", host_rdata, 16'h0);

    // Vector walk: R1 R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][34:33];
      big_endian = VEC[i][32];
      drive(op == 2'd0, op == 2'd1, op == 2'd2, op == 2'd3, VEC[i][31:16], VEC[i][23:16]);
      if (op == 2'd1) chk("R6 host read word", host_rdata, VEC[i][15:0]);
      if (op == 2'd3) chk("R1/R2/R3 popped byte", {8'h0, eng_tx_byte}, VEC[i][15:0]);
    end
    idle();

    // R4 underflow set, then cleared by write; R8 tx_ready
    do_reset();
    big_endian = 1'b0;
    drive(0, 0, 0, 1, 16'h0, 8'h0);
    chk("R4 empty pop byte", {8'h0, eng_tx_byte}, 16'h0);
    idle();
    chk("R4 underflow set", {15'h0, underflow}, 16'h1);
    chk("R8 tx_ready after pop", {15'h0, tx_ready}, 16'h1);
    drive(1, 0, 0, 0, 16'h0102, 8'h0);
    idle();
    chk("R4 underflow cleared", {15'h0, underflow}, 16'h0);
    chk("R8 tx_ready kept at 2", {15'h0, tx_ready}, 16'h1);
    drive(1, 0, 0, 0, 16'h0304, 8'h0);
    idle();
    chk("R8 tx_ready cleared at 4", {15'h0, tx_ready}, 16'h0);

    // R5 overrun and R9 rx_ready
    do_reset();
    for (int k = 0; k < 5; k++) drive(0, 0, 1, 0, 16'h0, 8'(k + 1));
    idle();
    chk("R5 overrun set", {15'h0, overrun}, 16'h1);
    chk("R9 rx_ready set", {15'h0, rx_ready}, 16'h1);
    drive(0, 1, 0, 0, 16'h0, 8'h0);
    chk("R5 dropped byte absent", host_rdata, 16'h0201);
    idle();
    chk("R5 overrun cleared", {15'h0, overrun}, 16'h0);
    chk("R9 rx_ready kept", {15'h0, rx_ready}, 16'h1);
    drive(0, 1, 0, 0, 16'h0, 8'h0);
    chk("R5 bytes 3,4 survive", host_rdata, 16'h0403);
    idle();
    chk("R9 rx_ready cleared", {15'h0, rx_ready}, 16'h0);

    // R7 single byte pulse
    do_reset();
    drive(0, 0, 1, 0, 16'h0, 8'h5A);
    drive(0, 1, 0, 0, 16'h0, 8'h0);
    chk("R7 lone byte", {8'h0, host_rdata[7:0]}, 16'h005A);
    idle();
    chk("R7 single pulse high", {15'h0, single_byte}, 16'h1);
    chk("R7 rx_ready cleared", {15'h0, rx_ready}, 16'h0);
    idle();
    chk("R7 single pulse low", {15'h0, single_byte}, 16'h0);

    // R10 same-cycle write + pop
    do_reset();
    big_endian = 1'b0;
    drive(1, 0, 0, 1, 16'h00C3, 8'h0);
    chk("R10 pop sees new write", {8'h0, eng_tx_byte}, 16'h00C3);
    idle();
    chk("R10 no underflow", {15'h0, underflow}, 16'h0);
    chk("R10 next byte", {8'h0, eng_tx_byte}, 16'h0000);

    // R10 same-cycle read + push
    do_reset();
    drive(0, 0, 1, 0, 16'h0, 8'h10);
    drive(0, 0, 1, 0, 16'h0, 8'h20);
    drive(0, 1, 1, 0, 16'h0, 8'h30);
    chk("R10 read before push", host_rdata, 16'h2010);
    drive(0, 1, 0, 0, 16'h0, 8'h0);
    chk("R10 push landed at 0", {8'h0, host_rdata[7:0]}, 16'h0030);
    idle();
    chk("R10 one byte was held", {15'h0, single_byte}, 16'h1);

    summary();
    $finish;
  end
endmodule